// File: doc/BRIEF.md
# Warp memory request coalescer

This block sits between the address stage of a 32-lane thread group and the memory port. It takes one memory instruction at a time: a byte address and an active flag for every lane, plus a granularity select. It reduces the active lanes to the fewest aligned transactions that together cover all of them. Each transaction carries an aligned base address and a mask of the lanes it serves. Lanes that fall into the same aligned region share a single transaction, so repeated or broadcast addresses cost one fetch.

Two granularities are supported. The coarse one uses a 128-byte aligned line and serves cached loads. The fine one uses a 32-byte aligned segment and serves uncached loads and stores. Transactions leave one per cycle through a valid/ready handshake. The block takes no new instruction until the last transaction of the current one has been accepted. A one-cycle completion pulse marks that point.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1 and txn_valid and done are 0.
- R2: With req_mode = 0 (line granularity), every transaction base is the lane address with its low 7 bits cleared, so bases are 128-byte aligned.
- R3: With req_mode = 1 (segment granularity), every transaction base is the lane address with its low 5 bits cleared, so bases are 32-byte aligned.
- R4: For one instruction, the number of transactions equals the number of distinct aligned regions touched by active lanes. Each active lane appears in exactly one mask. Inactive lanes (req_active bit 0) appear in no mask.
- R5: Transactions come out in order of the lowest-numbered active lane not yet served. Each mask holds every not-yet-served active lane whose address falls in that lane's region.
- R6: 32 consecutive 4-byte words starting on a 128-byte boundary, assigned to lanes in any permutation, give exactly 1 transaction in line mode and exactly 4 in segment mode.
- R7: 32 consecutive 4-byte words starting 8 bytes past a 128-byte boundary give exactly 2 transactions in line mode and 5 in segment mode.
- R8: If every active lane holds the same address, exactly one transaction is issued, with all active lanes in its mask.
- R9: An instruction with no active lane issues no transaction. done is 1 in the cycle after acceptance, and req_ready stays 1.
- R10: While txn_valid is 1 and txn_ready is 0, txn_valid, txn_base and txn_mask hold their values.
- R11: req_ready is 0 from acceptance of an instruction that has active lanes until done. done is 1 for the cycle right after the final transaction handshake, with txn_valid 0 and req_ready 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction present |
| req_ready | output | 1 | Block is idle and will take an instruction |
| req_mode | input | 1 | 0: 128-byte lines, 1: 32-byte segments |
| req_active | input | 32 | Per-lane active flags, bit i is lane i |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32*i+31:32*i] |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Memory port takes the transaction |
| txn_base | output | 32 | Aligned base address of the transaction |
| txn_mask | output | 32 | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse: instruction fully issued |

## Verification
The assertions assume the memory side behaves as a normal valid/ready consumer. They also assume that req_valid is only meaningful while req_ready is high, since the block ignores it otherwise. The stimulus drives req_valid only in idle cycles and drops it right after acceptance. It toggles txn_ready at random so that stalls with held outputs occur often. Addresses are drawn from windows of varying width, so that merges, partial merges and fully scattered patterns all appear next to the directed aligned, shifted, broadcast and empty cases.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    GRAN_LINE = 1'b0,
    GRAN_SEG  = 1'b1
  } gran_e;
endpackage

// File: rtl/coal_first_lane.sv
module coal_first_lane #(
  parameter int LANES = 32,
  parameter int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // lowest set bit wins
  always_comb begin
    idx = '0;
    any = |pend;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/coal_region_match.sv
module coal_region_match
  import coal_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 32,
  parameter int LINE_SH = 7,
  parameter int SEG_SH  = 5,
  parameter int IDX_W   = $clog2(LANES)
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [LANES-1:0]        pend,
  input  logic [IDX_W-1:0]        lead_idx,
  input  gran_e                   gran,
  output logic [LANES-1:0]        mask,
  output logic [ADDR_W-1:0]       base
);
  logic [ADDR_W-1:0] lead_addr;
  assign lead_addr = addr_flat[lead_idx*ADDR_W +: ADDR_W];

  // one comparator pair per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] a;
    logic same_line, same_seg;
    assign a         = addr_flat[g*ADDR_W +: ADDR_W];
    assign same_line = (a[ADDR_W-1:LINE_SH] == lead_addr[ADDR_W-1:LINE_SH]);
    assign same_seg  = (a[ADDR_W-1:SEG_SH]  == lead_addr[ADDR_W-1:SEG_SH]);
    assign mask[g]   = pend[g] & ((gran == GRAN_SEG) ? same_seg : same_line);
  end

  assign base = (gran == GRAN_SEG) ? {lead_addr[ADDR_W-1:SEG_SH], {SEG_SH{1'b0}}}
                                   : {lead_addr[ADDR_W-1:LINE_SH], {LINE_SH{1'b0}}};
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_mode,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_base,
  output logic [LANES-1:0]        txn_mask,
  output logic                    done
);
  localparam int IDX_W   = $clog2(LANES);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int SEG_SH  = $clog2(SEG_BYTES);

  logic                    busy;
  gran_e                   mode_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend_q;

  logic [IDX_W-1:0]  lead_idx;
  logic              lead_any;
  logic [LANES-1:0]  m_mask;
  logic [ADDR_W-1:0] m_base;
  logic              slot_free;

  coal_first_lane #(.LANES(LANES), .IDX_W(IDX_W)) u_first (
    .pend (pend_q),
    .idx  (lead_idx),
    .any  (lead_any)
  );

  coal_region_match #(
    .LANES(LANES), .ADDR_W(ADDR_W), .LINE_SH(LINE_SH), .SEG_SH(SEG_SH), .IDX_W(IDX_W)
  ) u_match (
    .addr_flat (addr_q),
    .pend      (pend_q),
    .lead_idx  (lead_idx),
    .gran      (mode_q),
    .mask      (m_mask),
    .base      (m_base)
  );

  assign slot_free = !txn_valid || txn_ready;
  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mode_q    <= GRAN_LINE;
      addr_q    <= '0;
      pend_q    <= '0;
      txn_valid <= 1'b0;
      txn_base  <= '0;
      txn_mask  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          addr_q <= req_addr;
          mode_q <= gran_e'(req_mode);
          pend_q <= req_active;
          if (req_active == '0) done <= 1'b1;
          else                  busy <= 1'b1;
        end
      end else if (slot_free) begin
        if (lead_any) begin
          txn_valid <= 1'b1;
          txn_base  <= m_base;
          txn_mask  <= m_mask;
          pend_q    <= pend_q & ~m_mask;
        end else begin
          txn_valid <= 1'b0;
          busy      <= 1'b0;
          done      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 32,
  parameter int LINE_SH = 7,
  parameter int SEG_SH  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_base,
  input logic [LANES-1:0]  txn_mask,
  input logic              done,
  input logic              mode_q
);
  AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    txn_valid && !mode_q |-> txn_base[LINE_SH-1:0] == '0); // R2
  AST_SEG_ALIGN: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> txn_base[SEG_SH-1:0] == '0); // R3
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> txn_mask != '0); // R4
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_mask)); // R10
  AST_NO_ACCEPT_MIDWAY: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> !req_ready); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !txn_valid && req_ready); // R9
endmodule

bind warp_coalescer coal_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .LINE_SH(LINE_SH), .SEG_SH(SEG_SH)
) chk_i (
  .clk(clk), .rst(rst), .req_ready(req_ready), .txn_valid(txn_valid),
  .txn_ready(txn_ready), .txn_base(txn_base), .txn_mask(txn_mask),
  .done(done), .mode_q(mode_q)
);

// File: tb/warp_coalescer_tb_top.sv
module warp_coalescer_tb_top;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_mode = 1'b0;
  logic [31:0]   req_active = '0;
  logic [1023:0] req_addr = '0;
  logic          txn_valid;
  logic          txn_ready = 1'b0;
  logic [31:0]   txn_base;
  logic [31:0]   txn_mask;
  logic          done;

  int vecs = 0;
  int errs = 0;

  logic [31:0] lane_a [32];
  logic [31:0] exp_base [32];
  logic [31:0] exp_mask [32];
  int          exp_cnt;

  always #2.5 clk = ~clk;

  warp_coalescer dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_active(req_active), .req_addr(req_addr),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
    .txn_mask(txn_mask), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] want);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: %s got %h expected %h", tag, what, got, want);
    end
  endtask

  function automatic logic [31:0] region(input logic [31:0] a, input logic mode);
    return mode ? (a & ~32'h1F) : (a & ~32'h7F);
  endfunction

  // reference: lowest unserved lane leads, takes all unserved lanes in its region
  function automatic void gen_model(input logic mode, input logic [31:0] act);
    logic [31:0] left, m, key;
    int lead;
    left = act;
    exp_cnt = 0;
    while (left != 0) begin
      lead = 0;
      for (int i = 31; i >= 0; i--) if (left[i]) lead = i;
      key = region(lane_a[lead], mode);
      m = '0;
      for (int i = 0; i < 32; i++)
        if (left[i] && region(lane_a[i], mode) == key) m[i] = 1'b1;
      exp_base[exp_cnt] = key;
      exp_mask[exp_cnt] = m;
      exp_cnt++;
      left &= ~m;
    end
  endfunction

  task automatic run_req(input logic mode, input logic [31:0] act,
                         input int want, input string want_tag);
    int n;
    bit held, expect_done, finished, rdy;
    logic [31:0] hb, hm;
    gen_model(mode, act);
    if (want >= 0) check(exp_cnt == want, want_tag, "model count", 64'(exp_cnt), 64'(want));
    @(negedge clk);
    req_valid = 1'b1;
    req_mode = mode;
    req_active = act;
    for (int i = 0; i < 32; i++) req_addr[32*i +: 32] = lane_a[i];
    check(req_ready == 1'b1, "R11", "req_ready idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    req_active = '0;
    if (act == '0) begin
      check(done == 1'b1, "R9", "done on empty", 64'(done), 64'd1);
      check(txn_valid == 1'b0, "R9", "txn_valid on empty", 64'(txn_valid), 64'd0);
      check(req_ready == 1'b1, "R9", "req_ready on empty", 64'(req_ready), 64'd1);
      return;
    end
    n = 0; held = 0; expect_done = 0; finished = 0;
    for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
      if (held) begin
        check(txn_valid && txn_base == hb && txn_mask == hm, "R10", "held base",
              64'(txn_base), 64'(hb));
        held = 0;
      end
      if (expect_done) begin
        check(done == 1'b1, "R11", "done after last", 64'(done), 64'd1);
        check(txn_valid == 1'b0 && req_ready == 1'b1, "R11", "idle at done",
              64'({txn_valid, req_ready}), 64'b01);
        check(n == exp_cnt, "R4", "transaction count", 64'(n), 64'(exp_cnt));
        finished = 1;
      end else begin
        if (done) begin
          check(1'b0, "R4", "early done, count", 64'(n), 64'(exp_cnt));
          finished = 1;
        end
        if (req_ready) check(1'b0, "R11", "req_ready while busy", 64'(req_ready), 64'd0);
        rdy = ($urandom % 4) != 0;
        txn_ready = rdy;
        if (txn_valid && !finished) begin
          if (rdy) begin
            if (n < exp_cnt) begin
              check(txn_base == exp_base[n], mode ? "R3" : "R2", "base",
                    64'(txn_base), 64'(exp_base[n]));
              check(txn_mask == exp_mask[n], "R5", "mask", 64'(txn_mask), 64'(exp_mask[n]));
            end else begin
              check(1'b0, "R4", "extra transaction", 64'(n + 1), 64'(exp_cnt));
            end
            n++;
            if (n == exp_cnt) expect_done = 1;
          end else begin
            held = 1; hb = txn_base; hm = txn_mask;
          end
        end
      end
      @(negedge clk);
    end
    txn_ready = 1'b0;
    if (!finished) check(1'b0, "R11", "no done within limit", 64'(n), 64'(exp_cnt));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    int perm [32];
    int j, t;
    logic [31:0] wbase, act;
    int span;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    check(txn_valid == 1'b0, "R1", "txn_valid after reset", 64'(txn_valid), 64'd0);
    check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);

    // R6: aligned, permuted
    for (int i = 0; i < 32; i++) perm[i] = i;
    for (int i = 31; i > 0; i--) begin
      j = $urandom % (i + 1); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    for (int i = 0; i < 32; i++) lane_a[i] = 32'h0000_2000 + 32'(perm[i] * 4);
    run_req(1'b0, 32'hFFFF_FFFF, 1, "R6");
    run_req(1'b1, 32'hFFFF_FFFF, 4, "R6");

    // R7: shifted by 8 bytes
    for (int i = 0; i < 32; i++) lane_a[i] = 32'h0000_3008 + 32'(i * 4);
    run_req(1'b0, 32'hFFFF_FFFF, 2, "R7");
    run_req(1'b1, 32'hFFFF_FFFF, 5, "R7");

    // R8: broadcast
    for (int i = 0; i < 32; i++) lane_a[i] = 32'hABCD_0124;
    run_req(1'b0, 32'hFFFF_FFFF, 1, "R8");
    run_req(1'b1, 32'h0F0F_00F3, 1, "R8");

    // R9: no active lanes
    run_req(1'b0, 32'h0, 0, "R9");
    run_req(1'b1, 32'h0, 0, "R9");

    // R4/R5: fully scattered, one lane active, top lane only
    for (int i = 0; i < 32; i++) lane_a[i] = 32'(i) * 32'h0000_1000 + 32'h40;
    run_req(1'b0, 32'hFFFF_FFFF, 32, "R4");
    run_req(1'b1, 32'h8000_0000, 1, "R4");

    // constrained random
    for (int k = 0; k < 160; k++) begin
      wbase = $urandom & ~32'h3;
      case ($urandom % 4)
        0: span = 8;
        1: span = 32;
        2: span = 96;
        default: span = 1024;
      endcase
      for (int i = 0; i < 32; i++) lane_a[i] = wbase + 32'(($urandom % span) * 4);
      case ($urandom % 4)
        0: act = 32'hFFFF_FFFF;
        1: act = $urandom & $urandom;
        2: act = 32'h1 << ($urandom % 32);
        default: act = $urandom;
      endcase
      run_req(1'($urandom % 2), act, -1, "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule